// File: doc/BRIEF.md
# Integer Add/Subtract Unit with Sticky Exception Flags

This unit adds or subtracts two 32-bit integers and holds a three-bit exception register beside the result. The first operand always comes from a register. The second comes from a register or from a 16-bit immediate that is sign-extended to full width. The operation code selects one of five forms:

- plain add
- reverse subtract, which returns the second operand minus the first
- carrying add
- carrying reverse subtract
- extended add, which also adds the stored carry

The carrying and extended forms write the carry flag. A separate enable makes any form record signed overflow.

The flag register carries over from one issued operation to the next. A carrying add of the low words can therefore be followed by an extended add of the high words to form a 64-bit sum. The summary-overflow bit keeps any overflow seen since it was last cleared. A dedicated clear input zeroes it together with the overflow bit. The result and the flags are registered, so both appear one cycle after issue.

Top module: `exflag_adder`

## Requirements
- R1: While `rst` is high at a clock edge, `result` and `flags` become zero.
- R2: Op code 0 (add) issued with `issue` high puts `opa + B` on `result` one cycle later, where B is the second operand. Op codes 2 and 4 return the same sum, with op 4 also adding the stored carry.
- R3: Op code 1 (reverse subtract) returns `B - opa`, not `opa - B`. Op code 3 returns the same value.
- R4: With `use_imm` high, B is `imm` sign-extended from 16 to 32 bits, and `opb` is ignored.
- R5: `flags` bit 0 is the carry flag CA, bit 1 is the overflow flag OV and bit 2 is the summary flag SO. Op 2 writes CA with the carry out of `opa + B`. Op 3 writes CA with the carry out of `B + ~opa + 1`, which is 1 exactly when B >= `opa` unsigned.
- R6: Op code 4 returns `opa + B + CA` using the stored CA, and writes the carry out of that sum back to CA.
- R7: Op codes 0 and 1 leave CA unchanged.
- R8: With `ovf_en` high, an issued operation sets OV to 1 if its result overflowed as signed arithmetic and to 0 otherwise. With `ovf_en` low, OV and SO keep their values.
- R9: SO is set whenever OV is set, and then stays set through later operations that do not overflow.
- R10: `so_clear` high zeroes SO and OV at that edge. It overrides any flag update in the same cycle, and CA and `result` still follow the operation.
- R11: When `issue` is low, or the op code is 5, 6 or 7, `result` and CA hold and OV and SO change only through `so_clear`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | An operation is applied in this cycle |
| op | input | 3 | Operation code (0 add, 1 reverse subtract, 2 carrying add, 3 carrying reverse subtract, 4 extended add) |
| use_imm | input | 1 | Use the sign-extended immediate as second operand |
| ovf_en | input | 1 | Record signed overflow in OV and SO |
| so_clear | input | 1 | Zero SO and OV |
| opa | input | 32 | First register operand |
| opb | input | 32 | Second register operand |
| imm | input | 16 | Immediate operand |
| result | output | 32 | Registered result |
| flags | output | 3 | Registered flags: [2] SO, [1] OV, [0] CA |

## Verification
The properties assume that every control input (`issue`, `op`, `ovf_en`, `so_clear`) holds a known 0 or 1 at every clock edge after reset. Under that assumption, "unchanged" can be compared with `$stable` directly. The stimulus drives every input from the first cycle, changes inputs only on falling edges, and draws reserved op codes and idle cycles on purpose so that the hold paths are exercised and not merely avoided. The stimulus raises `so_clear` both alone and together with overflowing operations, which tests the clear priority against a live update.

// File: rtl/exflag_pkg.sv
`timescale 1ns/1ps
package exflag_pkg;
  localparam int OP_W   = 3;
  localparam int FLAG_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 3'd0,
    OP_SUBF  = 3'd1,
    OP_ADDC  = 3'd2,
    OP_SUBFC = 3'd3,
    OP_ADDE  = 3'd4
  } op_e;

  typedef struct packed {
    logic so;
    logic ov;
    logic ca;
  } flags_t;

  function automatic logic op_known(input logic [OP_W-1:0] code);
    return code <= OP_ADDE;
  endfunction

  function automatic logic op_is_sub(input logic [OP_W-1:0] code);
    return (code == OP_SUBF) || (code == OP_SUBFC);
  endfunction

  function automatic logic op_writes_ca(input logic [OP_W-1:0] code);
    return (code == OP_ADDC) || (code == OP_SUBFC) || (code == OP_ADDE);
  endfunction
endpackage

// File: rtl/exflag_opsel.sv
`timescale 1ns/1ps
module exflag_opsel
  import exflag_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16
) (
  input  logic [OP_W-1:0]  op,
  input  logic             use_imm,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [IMM_W-1:0] imm,
  input  logic             ca_q,
  output logic [WIDTH-1:0] x,
  output logic [WIDTH-1:0] y,
  output logic             cin
);
  localparam int EXT_W = WIDTH - IMM_W;

  logic [WIDTH-1:0] b_eff;

  // The second operand is the register or the sign-extended immediate.
  assign b_eff = use_imm ? {{EXT_W{imm[IMM_W-1]}}, imm} : opb;

  // Reverse subtract is computed as b + ~a + 1 on the shared adder.
  always_comb begin
    x   = opa;
    y   = b_eff;
    cin = 1'b0;
    if (op_is_sub(op)) begin
      x   = b_eff;
      y   = ~opa;
      cin = 1'b1;
    end else if (op == OP_ADDE) begin
      cin = ca_q;
    end
  end
endmodule

// File: rtl/exflag_sum.sv
`timescale 1ns/1ps
module exflag_sum #(
  parameter int WIDTH  = 32,
  parameter bit RIPPLE = 1'b0
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             cin,
  output logic [WIDTH-1:0] s,
  output logic             cout,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;

  generate
    if (RIPPLE) begin : g_ripple
      logic [WIDTH:0] c;
      assign c[0] = cin;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign s[i]   = x[i] ^ y[i] ^ c[i];
        assign c[i+1] = (x[i] & y[i]) | (c[i] & (x[i] ^ y[i]));
      end
      assign cout = c[WIDTH];
      // Signed overflow: the carries into and out of the sign bit disagree.
      assign ovf  = c[WIDTH] ^ c[MSB];
    end else begin : g_flat
      logic [WIDTH:0] wide;
      assign wide = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
      assign s    = wide[MSB:0];
      assign cout = wide[WIDTH];
      // Signed overflow: the addends share a sign that the sum does not have.
      assign ovf  = (x[MSB] == y[MSB]) && (wide[MSB] != x[MSB]);
    end
  endgenerate
endmodule

// File: rtl/exflag_flags.sv
`timescale 1ns/1ps
module exflag_flags
  import exflag_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   upd,
  input  logic   wr_ca,
  input  logic   ovf_en,
  input  logic   so_clear,
  input  logic   cout,
  input  logic   ovf,
  output flags_t flags_q
);
  flags_t nxt;

  always_comb begin
    nxt = flags_q;
    if (upd && wr_ca) nxt.ca = cout;
    if (upd && ovf_en) begin
      nxt.ov = ovf;
      if (ovf) nxt.so = 1'b1;
    end
    // The clear overrides any overflow update made in the same cycle.
    if (so_clear) begin
      nxt.ov = 1'b0;
      nxt.so = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= nxt;
  end
endmodule

// File: rtl/exflag_adder.sv
`timescale 1ns/1ps
module exflag_adder
  import exflag_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int IMM_W  = 16,
  parameter bit RIPPLE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic [2:0]        op,
  input  logic              use_imm,
  input  logic              ovf_en,
  input  logic              so_clear,
  input  logic [WIDTH-1:0]  opa,
  input  logic [WIDTH-1:0]  opb,
  input  logic [IMM_W-1:0]  imm,
  output logic [WIDTH-1:0]  result,
  output logic [FLAG_W-1:0] flags
);
  logic [WIDTH-1:0] x, y, s;
  logic             cin, cout, ovf, upd;
  logic [WIDTH-1:0] result_q;
  flags_t           flags_q;

  assign upd = issue && op_known(op);

  exflag_opsel #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_opsel (
    .op(op), .use_imm(use_imm), .opa(opa), .opb(opb), .imm(imm),
    .ca_q(flags_q.ca), .x(x), .y(y), .cin(cin)
  );

  exflag_sum #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_sum (
    .x(x), .y(y), .cin(cin), .s(s), .cout(cout), .ovf(ovf)
  );

  exflag_flags u_flags (
    .clk(clk), .rst(rst), .upd(upd), .wr_ca(op_writes_ca(op)),
    .ovf_en(ovf_en), .so_clear(so_clear), .cout(cout), .ovf(ovf),
    .flags_q(flags_q)
  );

  always_ff @(posedge clk) begin
    if (rst)      result_q <= '0;
    else if (upd) result_q <= s;
  end

  assign result = result_q;
  assign flags  = flags_q;
endmodule

// File: rtl/exflag_adder_chk.sv
`timescale 1ns/1ps
module exflag_adder_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             issue,
  input logic [2:0]       op,
  input logic             ovf_en,
  input logic             so_clear,
  input logic [WIDTH-1:0] result,
  input logic [2:0]       flags
);
  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> (result == '0 && flags == 3'b000)); // R1
  AST_CA_KEPT: assert property (@(posedge clk) disable iff (rst)
    (issue && (op == 3'd0 || op == 3'd1)) |=> $stable(flags[0])); // R7
  AST_OV_KEPT: assert property (@(posedge clk) disable iff (rst)
    (!ovf_en && !so_clear) |=> $stable(flags[2:1])); // R8
  AST_OV_IMPLIES_SO: assert property (@(posedge clk) disable iff (rst)
    flags[1] |-> flags[2]); // R9
  AST_SO_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flags[2] && !so_clear) |=> flags[2]); // R9
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    so_clear |=> (flags[2:1] == 2'b00)); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!issue || op > 3'd4) |=> ($stable(result) && $stable(flags[0]))); // R11
endmodule

bind exflag_adder exflag_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .issue(issue), .op(op), .ovf_en(ovf_en),
  .so_clear(so_clear), .result(result), .flags(flags)
);

// File: tb/exflag_adder_tb.sv
`timescale 1ns/1ps
module exflag_adder_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue = 1'b0, use_imm = 1'b0, ovf_en = 1'b0, so_clear = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [31:0] opa = '0, opb = '0;
  logic [15:0] imm = '0;
  logic [31:0] result;
  logic [2:0]  flags;

  int vectors = 0;
  int fails   = 0;

  logic [31:0] m_res = '0;
  logic        m_ca = 1'b0, m_ov = 1'b0, m_so = 1'b0;

  always #2 clk = ~clk;

  exflag_adder u_dut (
    .clk(clk), .rst(rst), .issue(issue), .op(op), .use_imm(use_imm),
    .ovf_en(ovf_en), .so_clear(so_clear), .opa(opa), .opb(opb), .imm(imm),
    .result(result), .flags(flags)
  );

  task automatic compare(input string tag);
    vectors++;
    if (result !== m_res || flags !== {m_so, m_ov, m_ca}) begin
      fails++;
      $display("FAIL %s: result=%h flags=%b expected result=%h flags=%b",
               tag, result, flags, m_res, {m_so, m_ov, m_ca});
    end
  endtask

  // Drives one cycle of stimulus, advances the reference model, checks after the edge.
  task automatic step(input logic iss, input logic [2:0] o, input logic ui,
                      input logic oe, input logic clr, input logic [31:0] a,
                      input logic [31:0] b, input logic [15:0] im, input string tag);
    longint sa, sb, full;
    longint unsigned ua, ub;
    logic [31:0] bu;
    logic ov_now;
    issue = iss; op = o; use_imm = ui; ovf_en = oe; so_clear = clr;
    opa = a; opb = b; imm = im;
    bu = ui ? {{16{im[15]}}, im} : b;
    sa = longint'($signed(a));
    sb = longint'($signed(bu));
    ua = longint'(a);
    ub = longint'(bu);
    if (iss && o <= 3'd4) begin
      case (o)
        3'd1, 3'd3: full = sb - sa;
        3'd4:       full = sa + sb + longint'(m_ca);
        default:    full = sa + sb;
      endcase
      ov_now = (full > 64'sd2147483647) || (full < -64'sd2147483648);
      if (o == 3'd2) m_ca = (ua + ub) >= 64'd4294967296;
      if (o == 3'd3) m_ca = (bu >= a);
      if (o == 3'd4) m_ca = (ua + ub + longint'(m_ca)) >= 64'd4294967296;
      m_res = full[31:0];
      if (oe) begin
        m_ov = ov_now;
        if (ov_now) m_so = 1'b1;
      end
    end
    if (clr) begin
      m_ov = 1'b0;
      m_so = 1'b0;
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: run did not end");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    compare("R1 reset state");
    // R2 plain add
    step(1, 3'd0, 0, 0, 0, 32'd100, 32'd23, 16'h0, "R2 add");
    // R3 reverse subtract gives b - a
    step(1, 3'd1, 0, 0, 0, 32'd5, 32'd3, 16'h0, "R3 subtract order");
    // R4 negative immediate is sign extended
    step(1, 3'd0, 1, 0, 0, 32'd10, 32'hDEADBEEF, 16'hFFFF, "R4 imm sign extend");
    // R5 carrying add, low words of a 64-bit sum
    step(1, 3'd2, 0, 0, 0, 32'hFFFFFFFF, 32'd1, 16'h0, "R5 carry out");
    // R6 extended add consumes the carry
    step(1, 3'd4, 0, 0, 0, 32'd0, 32'd0, 16'h0, "R6 extended add");
    // R7 plain forms keep CA
    step(1, 3'd2, 0, 0, 0, 32'hFFFFFFFF, 32'd1, 16'h0, "R5 carry set");
    step(1, 3'd0, 0, 0, 0, 32'd1, 32'd1, 16'h0, "R7 add keeps CA");
    step(1, 3'd1, 0, 0, 0, 32'd9, 32'd1, 16'h0, "R7 subtract keeps CA");
    // R5 carrying subtract with borrow
    step(1, 3'd3, 0, 0, 0, 32'd9, 32'd1, 16'h0, "R5 subtract borrow");
    // R8 overflow not recorded without enable
    step(1, 3'd0, 0, 0, 0, 32'h7FFFFFFF, 32'd1, 16'h0, "R8 no enable");
    step(1, 3'd0, 0, 1, 0, 32'h7FFFFFFF, 32'd1, 16'h0, "R8 overflow");
    // R9 sticky summary
    step(1, 3'd0, 0, 1, 0, 32'd1, 32'd1, 16'h0, "R9 sticky");
    // R10 clear beats a simultaneous overflow
    step(1, 3'd2, 0, 1, 1, 32'h80000000, 32'h80000000, 16'h0, "R10 clear priority");
    // R11 idle and reserved codes hold
    step(0, 3'd0, 0, 1, 0, 32'h7FFFFFFF, 32'd5, 16'h0, "R11 idle");
    step(1, 3'd6, 0, 1, 0, 32'h7FFFFFFF, 32'd5, 16'h0, "R11 reserved op");
    for (int n = 0; n < 4000; n++) begin
      logic iss, ui, oe, clr;
      logic [2:0] o;
      string tag;
      iss = ($urandom_range(0, 9) != 0);
      o   = ($urandom_range(0, 15) == 0) ? 3'($urandom_range(5, 7)) : 3'($urandom_range(0, 4));
      ui  = ($urandom_range(0, 3) == 0);
      oe  = ($urandom_range(0, 1) == 1);
      clr = ($urandom_range(0, 19) == 0);
      if (clr)                  tag = "R10 random";
      else if (!iss || o > 4)   tag = "R11 random";
      else if (o == 3'd4)       tag = "R6 random";
      else if (o >= 3'd2)       tag = "R5 random";
      else if (oe)              tag = "R8 random";
      else if (ui)              tag = "R4 random";
      else if (o == 3'd1)       tag = "R3 random";
      else                      tag = "R2 random";
      step(iss, o, ui, oe, clr,
           ($urandom_range(0, 3) == 0) ? {1'b0, {31{1'b1}}} ^ 32'($urandom_range(0, 3)) : $urandom,
           $urandom, 16'($urandom), tag);
    end
    rst = 1'b1;
    m_res = '0; m_ca = 1'b0; m_ov = 1'b0; m_so = 1'b0;
    @(negedge clk);
    compare("R1 reset again");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule